// File: doc/BRIEF.md
# UART Interrupt Status and Masking Controller

This block keeps the interrupt state of a serial port. Eleven event sources, each delivered as a one-cycle set pulse, latch into a raw status vector. Software holds a mask register that picks which of those bits may raise an interrupt. It clears latched bits by writing ones to a clear port. The block drives six registered interrupt lines. One line merges every source. The other five each cover one group: receive, transmit, receive timeout, modem-line change and line error. This lets a system wire the merged line to one interrupt controller input, or route each group separately.

Software reads back the raw vector or the masked vector through one read-data port chosen by two select inputs. A transmit-character write strobe is a separate input because every character written for transmission raises the transmit status bit. The logic that detects the source events sits outside this block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A set pulse on `srcSet[i]` makes raw status bit i read as 1 from the clock edge that samples it. The bit meanings are: 0 ring indicator, 1 clear-to-send, 2 carrier detect, 3 data-set-ready, 4 receive, 5 transmit, 6 receive timeout, 7 framing error, 8 parity error, 9 break, 10 overrun.
- R2: A pulse on `txCharWr` sets raw bit 5 (transmit) at the sampling edge.
- R3: A cycle with `clrWrEn` high clears every raw bit whose `wrData` bit is 1 and leaves the other raw bits unchanged.
- R4: When a set (either `srcSet` or `txCharWr`) and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: A cycle with `maskWrEn` high loads `wrData` into the mask register. A mask bit of 1 enables that source.
- R6: With `rdRawSel` high, `rdData` shows the raw vector. With only `rdMaskSel` high, it shows raw AND mask. With neither select high it shows 0. The raw select takes priority over the masked select.
- R7: `irqOut[0]` (combined) is high when any of the eleven bits of raw AND mask is 1.
- R8: The group lines `irqOut[1]` through `irqOut[5]` cover these bits of raw AND mask: line 1 bit 4 (receive), line 2 bit 5 (transmit), line 3 bit 6 (timeout), line 4 bits 3..0 (modem), line 5 bits 10..7 (error).
- R9: Reset clears the raw vector, the mask and all six interrupt lines.
- R10: The interrupt lines are registered. Each one reflects the raw and mask state one clock after that state changes, including a change caused only by a mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSet | input | 11 | Per-source set pulses |
| txCharWr | input | 1 | Transmit-character write strobe; sets bit 5 |
| maskWrEn | input | 1 | Mask register write strobe |
| clrWrEn | input | 1 | Write-one-to-clear strobe |
| wrData | input | 11 | Write data for the mask or clear strobe |
| rdRawSel | input | 1 | Select the raw vector on rdData |
| rdMaskSel | input | 1 | Select the masked vector on rdData |
| rdData | output | 11 | Read data |
| irqOut | output | 6 | Interrupt lines: 0 combined, 1 rx, 2 tx, 3 timeout, 4 modem, 5 error |

## Verification
A corrupted raw or mask bit appears on `rdData` in the cycle right after the edge that stored it. It appears on the interrupt lines one clock later, so a wrong group decode shows on a single line while the combined line stays correct. The vector walk clears the status, programs a mask and pulses a source pattern for each entry, then compares both read views and all six lines against group masks that the bench computes on its own. Directed cases cover the set-versus-clear collision, partial clears, a mask-only change with its one-cycle lag, the read-select priority, and a reset applied while status and mask are nonzero.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 11;
  localparam int NUM_OUT = 6;

  localparam int SRC_RING    = 0;
  localparam int SRC_CTS     = 1;
  localparam int SRC_CARRIER = 2;
  localparam int SRC_DSRDY   = 3;
  localparam int SRC_RX      = 4;
  localparam int SRC_TX      = 5;
  localparam int SRC_TMO     = 6;
  localparam int SRC_FRAME   = 7;
  localparam int SRC_PARITY  = 8;
  localparam int SRC_BREAK   = 9;
  localparam int SRC_OVRUN   = 10;

  localparam int OUT_ALL   = 0;
  localparam int OUT_RX    = 1;
  localparam int OUT_TX    = 2;
  localparam int OUT_TMO   = 3;
  localparam int OUT_MODEM = 4;
  localparam int OUT_ERR   = 5;

  typedef logic [NUM_SRC-1:0] srcVec_t;
  typedef logic [NUM_OUT-1:0] irqVec_t;

  typedef struct packed {
    logic maskLoad;
    logic clrApply;
    logic txSet;
    logic rdRaw;
    logic rdMasked;
  } ctlStrobe_t;

  function automatic srcVec_t bitOf(int idx);
    srcVec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic srcVec_t grpMask(int outIdx);
    srcVec_t m;
    case (outIdx)
      OUT_ALL:   m = '1;
      OUT_RX:    m = bitOf(SRC_RX);
      OUT_TX:    m = bitOf(SRC_TX);
      OUT_TMO:   m = bitOf(SRC_TMO);
      OUT_MODEM: m = bitOf(SRC_RING) | bitOf(SRC_CTS) | bitOf(SRC_CARRIER) | bitOf(SRC_DSRDY);
      OUT_ERR:   m = bitOf(SRC_FRAME) | bitOf(SRC_PARITY) | bitOf(SRC_BREAK) | bitOf(SRC_OVRUN);
      default:   m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_irq_pkg::*;
(
  input  logic       maskWrEn,
  input  logic       clrWrEn,
  input  logic       txCharWr,
  input  logic       rdRawSel,
  input  logic       rdMaskSel,
  output ctlStrobe_t strobe
);
  always_comb begin
    strobe.maskLoad = maskWrEn;
    strobe.clrApply = clrWrEn;
    strobe.txSet    = txCharWr;
    // raw view has priority over the masked view
    strobe.rdRaw    = rdRawSel;
    strobe.rdMasked = rdMaskSel & ~rdRawSel;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  srcVec_t    srcSet,
  input  srcVec_t    wrData,
  output srcVec_t    rdData,
  output irqVec_t    irqOut,
  output srcVec_t    rawStat,
  output srcVec_t    maskStat
);
  srcVec_t rawQ, maskQ, rawNext, setVec, clrVec, enabled;
  irqVec_t irqQ;

  always_comb begin
    setVec  = srcSet | (strobe.txSet ? bitOf(SRC_TX) : '0);
    clrVec  = strobe.clrApply ? wrData : '0;
    // set beats clear on the same bit
    rawNext = (rawQ & ~clrVec) | setVec;
    enabled = rawQ & maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ  <= '0;
      maskQ <= '0;
    end else begin
      rawQ <= rawNext;
      if (strobe.maskLoad) maskQ <= wrData;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : gen_line
    localparam srcVec_t LINE_MASK = grpMask(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqQ[g] <= 1'b0;
      else       irqQ[g] <= |(enabled & LINE_MASK);
    end
  end

  always_comb begin
    if (strobe.rdRaw)         rdData = rawQ;
    else if (strobe.rdMasked) rdData = enabled;
    else                      rdData = '0;
  end

  assign irqOut   = irqQ;
  assign rawStat  = rawQ;
  assign maskStat = maskQ;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic               txCharWr,
  input  logic               maskWrEn,
  input  logic               clrWrEn,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               rdRawSel,
  input  logic               rdMaskSel,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_OUT-1:0] irqOut
);
  ctlStrobe_t strobe;
  srcVec_t    rawView, maskView;

  uart_irq_ctl ctl_i (
    .maskWrEn (maskWrEn),
    .clrWrEn  (clrWrEn),
    .txCharWr (txCharWr),
    .rdRawSel (rdRawSel),
    .rdMaskSel(rdMaskSel),
    .strobe   (strobe)
  );

  uart_irq_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcSet  (srcSet),
    .wrData  (wrData),
    .rdData  (rdData),
    .irqOut  (irqOut),
    .rawStat (rawView),
    .maskStat(maskView)
  );
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcSet,
  input logic               txCharWr,
  input logic               maskWrEn,
  input logic               clrWrEn,
  input logic [NUM_SRC-1:0] wrData,
  input logic               rdRawSel,
  input logic               rdMaskSel,
  input logic [NUM_SRC-1:0] rdData,
  input logic [NUM_OUT-1:0] irqOut,
  input logic [NUM_SRC-1:0] rawView,
  input logic [NUM_SRC-1:0] maskView
);
  logic [NUM_SRC-1:0] allSet, live;
  assign allSet = srcSet | ({{(NUM_SRC-1){1'b0}}, txCharWr} << 5);
  assign live   = rawView & maskView;

  // R1
  set_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|allSet) |=> ((rawView & $past(allSet)) == $past(allSet)));

  // R3
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrWrEn |=> ((rawView & $past(wrData & ~allSet)) == '0));

  // R4
  no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawView & ~$past(rawView) & ~$past(allSet)) == '0));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskWrEn |=> (maskView == $past(wrData)));

  // R6
  masked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdMaskSel && !rdRawSel) |-> (rdData == live));

  // R7
  combined_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut[0] == $past(|live)));

  // R8
  error_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut[5] == $past(|live[10:7])));

  // R8
  modem_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut[4] == $past(|live[3:0])));
endmodule

bind uart_irq_ctrl uart_irq_chk chk_i (
  .clk(clk), .rstN(rstN), .srcSet(srcSet), .txCharWr(txCharWr),
  .maskWrEn(maskWrEn), .clrWrEn(clrWrEn), .wrData(wrData),
  .rdRawSel(rdRawSel), .rdMaskSel(rdMaskSel), .rdData(rdData),
  .irqOut(irqOut), .rawView(rawView), .maskView(maskView)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] srcSet = '0;
  logic        txCharWr = 1'b0;
  logic        maskWrEn = 1'b0;
  logic        clrWrEn = 1'b0;
  logic [10:0] wrData = '0;
  logic        rdRawSel = 1'b0;
  logic        rdMaskSel = 1'b0;
  logic [10:0] rdData;
  logic [5:0]  irqOut;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  uart_irq_ctrl dut_i (.*);

  // {set pattern, mask}
  localparam logic [21:0] VEC [10] = '{
    {11'h7FF, 11'h7FF}, {11'h010, 11'h7FF}, {11'h020, 11'h000},
    {11'h040, 11'h040}, {11'h008, 11'h00F}, {11'h100, 11'h780},
    {11'h780, 11'h07F}, {11'h00F, 11'h001}, {11'h400, 11'h7FF},
    {11'h020, 11'h020}};

  // line groups taken from R7/R8
  function automatic logic [5:0] expLines(logic [10:0] m);
    return {|(m & 11'h780), |(m & 11'h00F), |(m & 11'h040),
            |(m & 11'h020), |(m & 11'h010), |m};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    srcSet = '0; txCharWr = 0; maskWrEn = 0; clrWrEn = 0; wrData = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic readRaw(output logic [10:0] v);
    rdRawSel = 1; rdMaskSel = 0; #1; v = rdData; rdRawSel = 0;
  endtask

  task automatic readMasked(output logic [10:0] v);
    rdRawSel = 0; rdMaskSel = 1; #1; v = rdData; rdMaskSel = 0;
  endtask

  task automatic clearAll();
    clrWrEn = 1; wrData = 11'h7FF; step();
  endtask

  task automatic loadMask(logic [10:0] m);
    maskWrEn = 1; wrData = m; step();
  endtask

  initial begin
    logic [10:0] rv;
    repeat (3) @(negedge clk);
    // R9 reset state
    readRaw(rv);    check("R9 raw after reset", rv, 0);
    readMasked(rv); check("R9 masked after reset", rv, 0);
    check("R9 lines after reset", irqOut, 0);
    rstN = 1;
    @(negedge clk);

    foreach (VEC[k]) begin
      logic [10:0] s, m;
      s = VEC[k][21:11];
      m = VEC[k][10:0];
      clearAll();
      loadMask(m);
      step(); // let lines settle on cleared state
      srcSet = s; step();
      readRaw(rv);    check("R1 raw after set", rv, s);
      readMasked(rv); check("R6 masked view", rv, s & m);
      @(negedge clk);
      check("R7 R8 lines", irqOut, expLines(s & m));
    end

    // R2 transmit-character write
    clearAll(); step();
    txCharWr = 1; step();
    readRaw(rv); check("R2 tx char sets bit 5", rv, 11'h020);

    // R3 partial clear
    clearAll();
    srcSet = 11'h0F3; step();
    clrWrEn = 1; wrData = 11'h0A1; step();
    readRaw(rv); check("R3 partial clear", rv, 11'h052);

    // R4 set beats clear
    clearAll();
    srcSet = 11'h300; step();
    srcSet = 11'h100; clrWrEn = 1; wrData = 11'h300; step();
    readRaw(rv); check("R4 set wins", rv, 11'h100);
    clearAll();
    txCharWr = 1; clrWrEn = 1; wrData = 11'h7FF; step();
    readRaw(rv); check("R4 tx set wins", rv, 11'h020);

    // R10 mask-only change lags one clock; R5 mask load
    clearAll(); loadMask(11'h000);
    srcSet = 11'h010; step();
    @(negedge clk);
    check("R10 masked off lines", irqOut, 0);
    maskWrEn = 1; wrData = 11'h010; step();
    readMasked(rv); check("R5 mask loaded", rv, 11'h010);
    check("R10 line not yet changed", irqOut, 0);
    @(negedge clk);
    check("R10 line after one clock", irqOut, 6'b000011);

    // R6 select priority and idle value
    rdRawSel = 1; rdMaskSel = 1; #1;
    check("R6 raw priority", rdData, 11'h010);
    rdRawSel = 0; rdMaskSel = 0; #1;
    check("R6 no select", rdData, 0);

    // R9 reset while active
    srcSet = 11'h7FF; loadMask(11'h7FF);
    @(negedge clk);
    rstN = 0; #1;
    check("R9 lines in reset", irqOut, 0);
    readRaw(rv); check("R9 raw in reset", rv, 0);
    @(negedge clk); rstN = 1;
    srcSet = 11'h010; step();
    @(negedge clk);
    readMasked(rv); check("R9 mask cleared", rv, 0);
    check("R9 lines stay low", irqOut, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errCnt++; chkCnt++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule